// File: doc/BRIEF.md
# Randomized RF Frame Burst Scheduler

This block paces the transmission of one RF datagram as a burst of repeated frames. Software loads a frame count, a base gap length in millisecond ticks, a pseudo-random seed and a tail-gap mode bit through a single parallel load strobe. The load is taken only while the block is idle. A start pulse then launches the burst. For each frame the block issues a one-cycle request to the transmitter and waits for the transmitter's frame-done pulse. It then counts a gap of millisecond ticks before it requests the next frame.

Each gap is the base length plus a pseudo-random offset taken from a 7-bit LFSR, so bursts from several emitters are unlikely to collide repeatedly. A seed of zero turns the random term off. When the last frame is done, the block sets a sticky completion flag, either at once or after one more full gap, depending on the mode bit. An interrupt output mirrors the flag only while the interrupt enable is high.

Top module: `rf_burst_sched`

## Requirements
- R1: A start pulse while idle begins a burst of exactly `cfg_frames_m1 + 1` frame requests (1 to 16). `cfg_frames_m1` is the 4-bit count captured by the last accepted `ld_cfg`.
- R2: `frame_req` is a one-cycle pulse. No further request is issued until `frame_done` has been seen for the current frame.
- R3: Between a `frame_done` and the next `frame_req`, exactly G `tick_ms` pulses are consumed, where G = base + random. Ticks are ignored outside a gap, and G = 0 gives back-to-back frames.
- R4: The base term is `cfg_base` (8 bits), except that values 1 to 4 count as 5. A value of 0 gives a base of 0.
- R5: The LFSR loads `cfg_seed` (7 bits) at start. The k-th gap of a burst uses the value after k-1 advances, with next = {l[5:0], l[6]^l[5]}. The random term is 0 when the seed is 0.
- R6: With `cfg_tail_gap` = 0, in the cycle after the last `frame_done` is taken, `busy` is low and `done_flag` is high.
- R7: With `cfg_tail_gap` = 1, after the last frame one more gap is counted, using the next LFSR value. `done_flag` rises in the cycle that `busy` falls.
- R8: `irq` is high exactly while `done_flag` is high and `irq_en` is high.
- R9: A `flag_clr` pulse clears `done_flag` (and so `irq`) by the next cycle.
- R10: Reset (`rst_n` low) idles the block, clears all outputs, and clears all four configuration fields. A start with no load therefore gives one frame and immediate completion.
- R11: `start` and `ld_cfg` during a burst are ignored. The burst length and the stored configuration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| ld_cfg | input | 1 | Load strobe for the four configuration fields (idle only) |
| cfg_frames_m1 | input | 4 | Frames per burst minus one |
| cfg_base | input | 8 | Base gap in ms ticks |
| cfg_seed | input | 7 | LFSR seed; 0 disables the random term |
| cfg_tail_gap | input | 1 | 1: add one gap after the last frame before completion |
| irq_en | input | 1 | Interrupt enable |
| start | input | 1 | Burst start pulse |
| tick_ms | input | 1 | Nominal 1 ms tick pulse |
| frame_done | input | 1 | Transmitter reports the current frame sent |
| flag_clr | input | 1 | Clears the completion flag |
| frame_req | output | 1 | One-cycle request to send a frame |
| busy | output | 1 | Burst in progress |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt, gated by `irq_en` |

## Verification
The hardest situation to reach from the ports is a gap of exact length that ends on a tick boundary. A tick arriving in the cycle a gap starts or ends would blur the count by one. The bench therefore ties `frame_done` to a fixed phase of its four-cycle tick pattern, which lets it count ticks exactly between handshake and request. It follows the LFSR sequence through bursts of up to sixteen frames, including the extra tail gap. Start and load pulses are injected in the middle of a burst, and the next burst is run without reloading to show that the stored fields survived.

// File: rtl/rf_burst_sched.sv
module rf_burst_sched #(
  parameter int CNT_W    = 4,
  parameter int BASE_W   = 8,
  parameter int SEED_W   = 7,
  parameter int BASE_MIN = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cfg,
  input  logic [CNT_W-1:0]  cfg_frames_m1,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [SEED_W-1:0] cfg_seed,
  input  logic              cfg_tail_gap,
  input  logic              irq_en,
  input  logic              start,
  input  logic              tick_ms,
  input  logic              frame_done,
  input  logic              flag_clr,
  output logic              frame_req,
  output logic              busy,
  output logic              done_flag,
  output logic              irq
);
  localparam int GAP_W = ((BASE_W > SEED_W) ? BASE_W : SEED_W) + 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_GAP} st_t;
  st_t st;

  logic [CNT_W-1:0]  r_fm1, left;
  logic [BASE_W-1:0] r_base, base_eff;
  logic [SEED_W-1:0] r_seed, lfsr, lfsr_nx;
  logic              r_tail, in_tail;
  logic [GAP_W-1:0]  gcnt, gap_len;
  logic              last, open_gap, finish;

  assign base_eff = (r_base != '0 && r_base < BASE_W'(BASE_MIN)) ? BASE_W'(BASE_MIN) : r_base;
  assign gap_len  = GAP_W'(base_eff) + ((r_seed == '0) ? '0 : GAP_W'(lfsr));
  assign lfsr_nx  = {lfsr[SEED_W-2:0], lfsr[SEED_W-1] ^ lfsr[SEED_W-2]};
  assign last     = (left == '0);
  assign open_gap = (st == S_WAIT) && frame_done && (!last || r_tail);
  assign finish   = ((st == S_WAIT) && frame_done && last && !r_tail) ||
                    ((st == S_GAP) && gcnt == '0 && in_tail);

  assign frame_req = (st == S_REQ);
  assign busy      = (st != S_IDLE);
  assign irq       = done_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_fm1  <= '0;
      r_base <= '0;
      r_seed <= '0;
      r_tail <= 1'b0;
    end else if (ld_cfg && st == S_IDLE) begin
      r_fm1  <= cfg_frames_m1;
      r_base <= cfg_base;
      r_seed <= cfg_seed;
      r_tail <= cfg_tail_gap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      left    <= '0;
      lfsr    <= '0;
      in_tail <= 1'b0;
      gcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_REQ;
          left    <= r_fm1;
          lfsr    <= r_seed;
          in_tail <= 1'b0;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (open_gap) begin
          st   <= S_GAP;
          gcnt <= gap_len;
          lfsr <= lfsr_nx;
          if (last) in_tail <= 1'b1;
          else      left    <= left - 1'b1;
        end else if (frame_done) begin
          st <= S_IDLE;
        end
        S_GAP: if (gcnt == '0) st <= in_tail ? S_IDLE : S_REQ;
               else if (tick_ms) gcnt <= gcnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_flag <= 1'b0;
    else        done_flag <= finish | (done_flag & ~flag_clr);
  end
endmodule

module rf_burst_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic frame_done,
  input logic flag_clr,
  input logic frame_req,
  input logic busy,
  input logic done_flag
);
  logic outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outst <= 1'b0;
    else if (frame_req)  outst <= 1'b1;
    else if (frame_done) outst <= 1'b0;
  end

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |=> !frame_req);
  assert_req_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |-> !outst);
  assert_start_begins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
  assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(busy));
  assert_clr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !busy) |=> !done_flag);
endmodule

bind rf_burst_sched rf_burst_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .frame_done(frame_done),
  .flag_clr(flag_clr), .frame_req(frame_req), .busy(busy), .done_flag(done_flag)
);

// File: tb/rf_burst_sched_tb.sv
`timescale 1ns/1ps
module rf_burst_sched_tb;
  logic clk = 0, rst_n = 0;
  logic ld_cfg = 0, cfg_tail_gap = 0, irq_en = 0, start = 0, tick_ms = 0;
  logic frame_done = 0, flag_clr = 0;
  logic [3:0] cfg_frames_m1 = 0;
  logic [7:0] cfg_base = 0;
  logic [6:0] cfg_seed = 0;
  logic frame_req, busy, done_flag, irq;

  int checks = 0, fails = 0, ticks = 0, ph = 0;
  int m_fm1 = 0, m_base = 0, m_seed = 0, m_tail = 0;

  always #4 clk = ~clk;

  rf_burst_sched u_dut (
    .clk(clk), .rst_n(rst_n), .ld_cfg(ld_cfg), .cfg_frames_m1(cfg_frames_m1),
    .cfg_base(cfg_base), .cfg_seed(cfg_seed), .cfg_tail_gap(cfg_tail_gap),
    .irq_en(irq_en), .start(start), .tick_ms(tick_ms), .frame_done(frame_done),
    .flag_clr(flag_clr), .frame_req(frame_req), .busy(busy),
    .done_flag(done_flag), .irq(irq)
  );

  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    tick_ms = (ph == 0);
  end
  always @(posedge clk) if (tick_ms) ticks = ticks + 1;

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lfsr_next(input int l);
    return ((l << 1) & 7'h7E) | (((l >> 6) ^ (l >> 5)) & 1);
  endfunction

  function automatic int eff_base(input int b);
    return (b != 0 && b < 5) ? 5 : b;
  endfunction

  task automatic burst(input int fm1, input int b, input int s, input int h,
                       input int en, input bit load, input bit poke);
    int ml, frames, t0, n, exp_g;
    bit lastf;
    if (load) begin
      cfg_frames_m1 = fm1[3:0]; cfg_base = b[7:0]; cfg_seed = s[6:0];
      cfg_tail_gap = h[0]; ld_cfg = 1; step(); ld_cfg = 0;
      m_fm1 = fm1; m_base = b; m_seed = s; m_tail = h;
    end
    irq_en = en[0];
    start = 1; step(); start = 0;
    ml = m_seed; frames = 0; n = 0;
    while (!frame_req && n < 20) begin step(); n++; end
    while (frame_req) begin
      frames++;
      step();
      chk("R2 request is single cycle", frame_req, 0);
      if (poke && frames == 1) begin
        start = 1; ld_cfg = 1; cfg_frames_m1 = ~cfg_frames_m1; cfg_seed = ~cfg_seed;
        step(); start = 0; ld_cfg = 0;
        chk("R11 no request without frame_done", frame_req, 0);
      end
      while (ph != 2) step();
      frame_done = 1; t0 = ticks; step(); frame_done = 0; n = 1;
      while (!frame_req && busy && n < 4000) begin step(); n++; end
      lastf = (frames == m_fm1 + 1);
      if (!lastf || m_tail != 0) begin
        exp_g = eff_base(m_base) + ((m_seed != 0) ? ml : 0);
        ml = lfsr_next(ml);
        chk(lastf ? "R7 tail gap ticks" : "R3/R4/R5 gap ticks", ticks - t0, exp_g);
      end else begin
        chk("R6 completion one cycle after last frame_done", n, 1);
      end
      if (frames > 16) break;
    end
    chk(poke ? "R11 frames unchanged by mid-burst start/load" : "R1 frame count",
        frames, m_fm1 + 1);
    chk("R6/R7 busy low at end", busy, 0);
    chk("R6/R7 done_flag set", done_flag, 1);
    chk("R8 irq follows enable", irq, en);
    flag_clr = 1; step(); flag_clr = 0;
    chk("R9 flag cleared", done_flag, 0);
    chk("R9 irq cleared", irq, 0);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    step(); step();
    chk("R10 reset frame_req", frame_req, 0);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done_flag", done_flag, 0);
    chk("R10 reset irq", irq, 0);
    rst_n = 1; step();
    burst(0, 0, 0, 0, 1, 0, 0);
    burst(1, 3, 0, 0, 1, 1, 0);
    burst(2, 6, 7'h41, 1, 0, 1, 0);
    burst(15, 0, 1, 0, 1, 1, 0);
    burst(3, 5, 7'h7F, 0, 1, 1, 1);
    burst(0, 0, 0, 0, 0, 0, 0);
    burst(1, 255, 0, 0, 1, 1, 0);
    burst(0, 7, 7'h12, 1, 1, 1, 0);
    for (int i = 0; i < 10; i++) begin
      burst($urandom % 8, $urandom % 40, $urandom % 128, $urandom % 2,
            $urandom % 2, 1, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule